// File: doc/BRIEF.md
# SHA-256 Three-Round Precompute Unit

This unit advances a SHA-256 hash state by three compression rounds ahead of time, so that a downstream hashing core can begin its work partway into the round sequence. It accepts a 20-word work vector in parallel. Words 0 to 7 hold the eight working variables a through h. Words 16 to 18 hold the message words for the first three rounds. On an accepted start pulse the unit captures the vector and runs one round per clock, three rounds in all. It then presents the advanced state in words 8 to 15, in reversed slot order. All other words come back exactly as they were supplied.

A single-cycle done pulse marks the cycle in which the result is first valid. The result stays on the output until the next start is accepted. A start that arrives while the unit is still working is dropped. The round constants are the first three standard SHA-256 constants, and all additions wrap modulo 2^32.

Top module: `midstate_advance`

## Requirements
- R1: On an accepted start, working variables a, b, c, d, e, f, g and h are taken from input words 0, 1, 2, 3, 4, 5, 6 and 7 respectively.
- R2: Round r (r = 0, 1, 2) uses message word 16+r and constant 428a2f98, 71374491 or b5c0fbcf. Call T the sum of the message word, the constant, h, Ch(e,f,g) and Sigma1(e), where Sigma1 XORs rotations right by 6, 11 and 25. The new e is T+d. The new a is T + Sigma0(a) + Maj(a,b,c), where Sigma0 XORs rotations right by 2, 13 and 22. The other variables shift: b←a, c←b, d←c, f←e, g←f, h←g. All sums are modulo 2^32.
- R3: Exactly three rounds are applied per accepted start, no more and no fewer.
- R4: The result appears in reversed order: output word 15 carries a, word 14 b, word 13 c, word 12 d, word 11 e, word 10 f, word 9 g and word 8 h.
- R5: Output words 0 to 7 and 16 to 19 equal the input words captured at the accepted start.
- R6: A start is accepted when busy is low. Busy is then high for the next three cycles. Done is high for exactly one cycle, the third cycle after the accepting edge, and busy is low in that cycle.
- R7: A start pulse while busy is high is ignored. It neither changes the captured vector nor alters the timing of done.
- R8: While reset is asserted and after it is released, busy and done are low.
- R9: After done, the output vector holds its value until the next start is accepted. A start in the done cycle itself is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Start request, sampled on a rising edge |
| vecIn | input | 20x32 | Work vector in, word i at bits [32i+31:32i] |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle pulse when the result is first valid |
| vecOut | output | 20x32 | Work vector out with words 8 to 15 replaced by the advanced state |

## Verification
A start sampled at rising edge E drives busy high after E, E+1 and E+2. Done and the final vector appear after edge E+3, and the value holds from then on. The bench drives inputs on falling edges and samples each output on the falling edge just after the register that produces it. It reads busy after E, E+1 and E+2, and reads done and the result after E+3. It then checks one falling edge later that done has dropped and the value has held. Expected vectors come from a round model inside the bench. The ignored-start and back-to-back cases reuse the same edge count, measured from the start that was actually accepted.

// File: rtl/midadv_pkg.sv
package midadv_pkg;
  localparam int WORD_W = 32;
  localparam int NUM_VARS = 8;
  localparam int IDX_W = 3;

  typedef logic [WORD_W-1:0] wordT;
  typedef wordT [0:NUM_VARS-1] varsT;  // index 0 = a ... 7 = h

  typedef struct packed {
    logic load;
    logic step;
    logic [IDX_W-1:0] idx;
  } ctlT;

  function automatic wordT rotr(wordT x, int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic wordT roundK(logic [IDX_W-1:0] i);
    case (i)
      3'd0: return 32'h428a2f98;
      3'd1: return 32'h71374491;
      3'd2: return 32'hb5c0fbcf;
      3'd3: return 32'he9b5dba5;
      3'd4: return 32'h3956c25b;
      3'd5: return 32'h59f111f1;
      3'd6: return 32'h923f82a4;
      default: return 32'hab1c5ed5;
    endcase
  endfunction

  function automatic varsT doRound(varsT v, wordT w, wordT k);
    varsT r;
    wordT chV, majV, s0, s1, t;
    chV  = (v[4] & v[5]) ^ (~v[4] & v[6]);
    majV = (v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]);
    s1   = rotr(v[4], 6) ^ rotr(v[4], 11) ^ rotr(v[4], 25);
    s0   = rotr(v[0], 2) ^ rotr(v[0], 13) ^ rotr(v[0], 22);
    t    = w + k + v[7] + chV + s1;
    r[0] = t + s0 + majV;
    r[1] = v[0];
    r[2] = v[1];
    r[3] = v[2];
    r[4] = t + v[3];
    r[5] = v[4];
    r[6] = v[5];
    r[7] = v[6];
    return r;
  endfunction
endpackage

// File: rtl/midadv_ctrl.sv
module midadv_ctrl
  import midadv_pkg::*;
#(
  parameter int NUM_ROUNDS = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  output ctlT  ctl,
  output logic busy,
  output logic done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ROUNDS - 1);

  logic [IDX_W-1:0] idx;

  always_comb begin
    ctl.load = start && !busy;
    ctl.step = busy;
    ctl.idx  = idx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      done <= 1'b0;
      idx  <= '0;
    end else begin
      done <= 1'b0;
      if (ctl.load) begin
        busy <= 1'b1;
        idx  <= '0;
      end else if (busy) begin
        if (idx == LAST_IDX) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/midadv_dpath.sv
module midadv_dpath
  import midadv_pkg::*;
#(
  parameter int VEC_WORDS = 20,
  parameter int OUT_BASE  = 8,
  parameter int MSG_BASE  = 16
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  ctlT                               ctl,
  input  logic [VEC_WORDS-1:0][WORD_W-1:0]  vecIn,
  output logic [VEC_WORDS-1:0][WORD_W-1:0]  vecOut
);
  localparam int OUT_TOP = OUT_BASE + NUM_VARS - 1;

  varsT vars, nextVars;
  logic [VEC_WORDS-1:0][WORD_W-1:0] heldW;
  wordT msgWord;

  always_comb begin
    msgWord  = heldW[MSG_BASE + int'(ctl.idx)];
    nextVars = doRound(vars, msgWord, roundK(ctl.idx));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vars <= '0;
    end else if (ctl.load) begin
      for (int j = 0; j < NUM_VARS; j++) vars[j] <= vecIn[j];
    end else if (ctl.step) begin
      vars <= nextVars;
    end
  end

  for (genvar i = 0; i < VEC_WORDS; i++) begin : g_word
    if (i >= OUT_BASE && i <= OUT_TOP) begin : g_res
      logic unusedW;
      assign unusedW   = ^vecIn[i];
      assign heldW[i]  = '0;
      assign vecOut[i] = vars[OUT_TOP - i];
    end else begin : g_keep
      wordT keepW;
      always_ff @(posedge clk) begin
        if (!rstN) keepW <= '0;
        else if (ctl.load) keepW <= vecIn[i];
      end
      assign heldW[i]  = keepW;
      assign vecOut[i] = keepW;
    end
  end
endmodule

// File: rtl/midstate_advance.sv
module midstate_advance
  import midadv_pkg::*;
#(
  parameter int VEC_WORDS  = 20,
  parameter int NUM_ROUNDS = 3,
  parameter int OUT_BASE   = 8,
  parameter int MSG_BASE   = 16
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              start,
  input  logic [VEC_WORDS-1:0][WORD_W-1:0]  vecIn,
  output logic                              busy,
  output logic                              done,
  output logic [VEC_WORDS-1:0][WORD_W-1:0]  vecOut
);
  ctlT ctl;

  midadv_ctrl #(.NUM_ROUNDS(NUM_ROUNDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .ctl(ctl), .busy(busy), .done(done)
  );

  midadv_dpath #(.VEC_WORDS(VEC_WORDS), .OUT_BASE(OUT_BASE), .MSG_BASE(MSG_BASE)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .vecIn(vecIn), .vecOut(vecOut)
  );
endmodule

// File: rtl/midadv_chk.sv
module midadv_chk #(
  parameter int VEC_WORDS  = 20,
  parameter int NUM_ROUNDS = 3
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    start,
  input logic                    busy,
  input logic                    done,
  input logic [VEC_WORDS*32-1:0] vecOut
);
  logic [3:0] sinceStart;

  always_ff @(posedge clk) begin
    if (!rstN) sinceStart <= 4'hf;
    else if (start && !busy) sinceStart <= '0;
    else if (sinceStart != 4'hf) sinceStart <= sinceStart + 1'b1;
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R3
  done_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (sinceStart == 4'(NUM_ROUNDS)));

  // R7
  ignore_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && busy) |=> $stable(vecOut[255:0]));

  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(vecOut));
endmodule

bind midstate_advance midadv_chk #(.VEC_WORDS(VEC_WORDS), .NUM_ROUNDS(NUM_ROUNDS)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done), .vecOut(vecOut)
);

// File: tb/midstate_advance_tb.sv
`timescale 1ns/1ps
module midstate_advance_tb;
  typedef logic [19:0][31:0] vecT;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  vecT vecIn = '0;
  vecT vecOut;
  logic busy, done;
  int nChk = 0;
  int nFail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  midstate_advance u_dut (
    .clk(clk), .rstN(rstN), .start(start), .vecIn(vecIn),
    .busy(busy), .done(done), .vecOut(vecOut)
  );

  // rows: 8 state words (a..h) then message words for rounds 0..2
  localparam logic [31:0] TAB [4][11] = '{
    '{32'hb0e72d8e, 32'h1dc5b862, 32'he9e7c4a6, 32'h3050f1f5, 32'h8a1a6b7e, 32'h7ec384e8,
      32'h42c1c3fc, 32'h8ed158a1, 32'h8a0bb7b7, 32'h33af304f, 32'h0b290c1a},
    '{32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0},
    '{32'hffffffff, 32'hffffffff, 32'hffffffff, 32'hffffffff, 32'hffffffff, 32'hffffffff,
      32'hffffffff, 32'hffffffff, 32'hffffffff, 32'hffffffff, 32'hffffffff},
    '{32'h01234567, 32'h89abcdef, 32'hfedcba98, 32'h76543210, 32'h13579bdf, 32'h2468ace0,
      32'h0f1e2d3c, 32'h4b5a6978, 32'h11111111, 32'h80000000, 32'h00000280}
  };
  localparam logic [31:0] KC [3] = '{32'h428a2f98, 32'h71374491, 32'hb5c0fbcf};

  function automatic logic [31:0] rr(logic [31:0] x, int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic vecT mkVec(int r);
    vecT v;
    for (int i = 0; i < 20; i++) v[i] = 32'hc0de0000 + 32'(r * 256 + i);
    for (int i = 0; i < 8; i++) v[i] = TAB[r][i];
    for (int i = 0; i < 3; i++) v[16 + i] = TAB[r][8 + i];
    return v;
  endfunction

  function automatic vecT model(vecT v);
    logic [31:0] a, b, c, d, e, f, g, h, t, ch, mj;
    vecT o;
    {a, b, c, d, e, f, g, h} = {v[0], v[1], v[2], v[3], v[4], v[5], v[6], v[7]};
    for (int r = 0; r < 3; r++) begin
      ch = (e & f) ^ (~e & g);
      mj = (a & b) ^ (a & c) ^ (b & c);
      t = v[16 + r] + KC[r] + h + ch + (rr(e, 6) ^ rr(e, 11) ^ rr(e, 25));
      h = g; g = f; f = e; e = t + d;
      d = c; c = b; b = a;
      a = t + (rr(a, 2) ^ rr(a, 13) ^ rr(a, 22)) + mj;
    end
    o = v;
    {o[15], o[14], o[13], o[12], o[11], o[10], o[9], o[8]} = {a, b, c, d, e, f, g, h};
    return o;
  endfunction

  task automatic chkBit(string tag, logic act, logic exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic chkVec(string tag, vecT act, vecT exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chkWords(string tag, vecT act, vecT exp, int lo, int hi);
    logic ok = 1'b1;
    for (int i = lo; i <= hi; i++) if (act[i] !== exp[i]) ok = 1'b0;
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: words %0d..%0d got %h expected %h", tag, lo, hi, act, exp);
    end
  endtask

  task automatic launch(vecT v);
    vecIn = v;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // after launch: at negedge following accepting edge E
  task automatic waitResult(vecT exp, string tag);
    chkBit({tag, " R6 busy after E"}, busy, 1'b1);
    @(negedge clk);
    @(negedge clk);
    chkBit({tag, " R6 no early done"}, done, 1'b0);
    @(negedge clk);
    chkBit({tag, " R6 done at E+3"}, done, 1'b1);
    chkBit({tag, " R6 busy low with done"}, busy, 1'b0);
    chkWords({tag, " R1 R2 R3 R4 advanced state"}, vecOut, exp, 8, 15);
    chkWords({tag, " R5 low pass-through"}, vecOut, exp, 0, 7);
    chkWords({tag, " R5 high pass-through"}, vecOut, exp, 16, 19);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    vecT e0, e1;
    repeat (3) @(negedge clk);
    chkBit("R8 busy in reset", busy, 1'b0);
    chkBit("R8 done in reset", done, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    chkBit("R8 busy after reset", busy, 1'b0);
    chkBit("R8 done after reset", done, 1'b0);

    // table walk
    for (int r = 0; r < 4; r++) begin
      launch(mkVec(r));
      waitResult(model(mkVec(r)), $sformatf("vec%0d", r));
      @(negedge clk);
      chkBit("R6 done one cycle", done, 1'b0);
      repeat (2) @(negedge clk);
      chkVec("R9 R3 result held", vecOut, model(mkVec(r)));
    end

    // R7: start while busy ignored
    e0 = model(mkVec(0));
    launch(mkVec(0));
    vecIn = mkVec(3);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chkBit("R7 busy kept", busy, 1'b1);
    @(negedge clk);
    chkBit("R7 no early done", done, 1'b0);
    @(negedge clk);
    chkBit("R7 done on original timing", done, 1'b1);
    chkVec("R7 result from first vector", vecOut, e0);

    // R9: start in the done cycle is accepted
    e1 = model(mkVec(3));
    launch(mkVec(2));
    chkBit("R9 start in done cycle accepted", busy, 1'b1);
    waitResult(model(mkVec(2)), "b2b");
    launch(mkVec(3));
    waitResult(e1, "b2b2");

    // R8: reset while busy
    launch(mkVec(1));
    rstN = 1'b0;
    @(negedge clk);
    chkBit("R8 reset clears busy", busy, 1'b0);
    chkBit("R8 reset clears done", done, 1'b0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chkBit("R8 no done after reset abort", done, 1'b0);

    finished = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule